// File: doc/BRIEF.md
# DDR SDRAM Command and Power-State Tracker

This block follows the control side of a double-data-rate SDRAM as a synchronous model. At each rising clock edge it samples chip select, the three command strobes, the bank address and the address bus. From these it decodes the command. It keeps a table of open rows for the four banks and holds the last mode and extended-mode op-codes. It also follows the power state that clock enable selects. A controller or a monitor can place it beside a memory port to see the state the device should be in and to catch command sequences that are not allowed.

The decoded command, the bank table, the op-codes and the error flag are registered. Each one changes after the edge on which the command is sampled. One path is not registered: leaving self refresh. While the tracker is in self refresh, the power-state output returns to active as soon as clock enable rises, without waiting for a clock edge.

Top module: `ddr_ctl_tracker`

## Requirements
- R1: With chip select low, the command strobes (RAS, CAS, WE) decode as follows: 011 Activate, 101 Read, 100 Write, 010 Precharge, 001 Refresh, 000 mode-register set, 111 No-Op. The code 110 is also treated as No-Op. `cmd_o` reports the executed command after the sampling edge: 0 No-Op, 1 Activate, 2 Read, 3 Write, 4 Precharge, 5 Refresh, 6 mode set, 7 extended mode set.
- R2: When chip select is sampled high, the strobes are ignored. `cmd_o` shows 0 and the bank table does not change.
- R3: An Activate to a closed bank marks the bank named by `ba_i` as open and stores `addr_i` as its row. Bank b's row is `bank_row_o[b*ADDR_W +: ADDR_W]`.
- R4: A Precharge with address bit 10 high closes all banks. With bit 10 low it closes only the bank given by `ba_i`.
- R5: In a mode-register set, `ba_i[0]`=0 selects the mode register (`cmd_o`=6) and 1 selects the extended mode register (`cmd_o`=7). The op-code on `addr_i` is stored in `mode_reg_o` or `ext_mode_reg_o`.
- R6: Two cases raise `err_o` for one cycle and leave the bank table unchanged: an Activate to a bank that is already open, and a Read or Write to a closed bank.
- R7: Clock enable sampled low in the active state with every bank idle enters precharge power-down (`pwr_state_o`=1). If a Refresh is sampled on the same edge, it enters self refresh instead (`pwr_state_o`=3, `cmd_o`=5).
- R8: Clock enable sampled low in the active state with any row open enters active power-down (`pwr_state_o`=2). The active state is 0.
- R9: In power-down or self refresh, sampled commands are ignored, and that includes the edge of exit. Power-down is left when clock enable is high at a clock edge.
- R10: In self refresh, `pwr_state_o` goes back to 0 as soon as clock enable rises, before the next clock edge.
- R11: An access lasts from the Read or Write edge through the following `ACC_CYC` edges. Clock enable sampled low at any of these edges raises `err_o`, and the tracker stays in the active state.
- R12: After reset, `cmd_o`, `bank_open_o`, `bank_row_o`, the op-code outputs, `err_o` and `pwr_state_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BANK_W | Bank address |
| addr_i | input | ADDR_W | Row, column or op-code |
| cmd_o | output | 3 | Executed command code |
| bank_open_o | output | NUM_BANKS | Per-bank open flag |
| bank_row_o | output | NUM_BANKS*ADDR_W | Per-bank open row |
| mode_reg_o | output | ADDR_W | Stored mode op-code |
| ext_mode_reg_o | output | ADDR_W | Stored extended op-code |
| pwr_state_o | output | 2 | Power state |
| err_o | output | 1 | Illegal-sequence flag |

## Verification
The bench builds the block with four banks and a 12-bit address, which places address bit 10 and the bank index as the requirements describe. It shortens `ACC_CYC` to 2. With the shorter window, one directed sequence can drop clock enable on the last edge of an access and see an error, then drop it again one edge later and see active power-down. It also raises clock enable in the middle of a clock cycle during self refresh, which checks the exit path that does not wait for a clock edge.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6,
    CMD_EMRS = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ACT  = 2'd0,
    PWR_PPD  = 2'd1,
    PWR_APD  = 2'd2,
    PWR_SREF = 2'd3
  } pwr_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_trk_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [BANK_W-1:0] ba_i,
  output cmd_e              cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = ba_i[0] ? CMD_EMRS : CMD_MRS;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       act_i,
  input  logic                       pre_i,
  input  logic                       pre_all_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [ROW_W-1:0]           row_i,
  output logic [NUM_BANKS-1:0]       open_o,
  output logic [NUM_BANKS*ROW_W-1:0] row_o
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             hit;

    assign hit = (bank_i == BANK_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (act_i && hit) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (pre_i && (pre_all_i || hit)) begin
        open_q <= 1'b0;
      end
    end

    assign open_o[g]                 = open_q;
    assign row_o[g*ROW_W +: ROW_W]   = row_q;
  end
endmodule

// File: rtl/ddr_pwr_fsm.sv
module ddr_pwr_fsm
  import ddr_trk_pkg::*;
#(
  parameter int ACC_CYC = 4,
  localparam int CNT_W  = $clog2(ACC_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic ref_i,
  input  logic rdwr_i,
  input  logic start_acc_i,
  input  logic any_open_i,
  output pwr_e state_o,
  output logic exec_o,
  output logic sref_entry_o,
  output logic cke_err_o
);
  pwr_e             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy, in_act;

  assign in_act = (state_q == PWR_ACT);
  assign busy   = (cnt_q != '0);

  assign exec_o       = in_act && cke_i;
  assign cke_err_o    = in_act && !cke_i && (busy || rdwr_i);
  assign sref_entry_o = in_act && !cke_i && !cke_err_o && ref_i && !any_open_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_ACT: begin
        if (!cke_i && !cke_err_o) begin
          if (any_open_i) state_d = PWR_APD;
          else if (ref_i) state_d = PWR_SREF;
          else            state_d = PWR_PPD;
        end
      end
      default: if (cke_i) state_d = PWR_ACT;
    endcase
  end

  always_comb begin
    if (start_acc_i) cnt_d = CNT_W'(ACC_CYC);
    else if (busy)   cnt_d = cnt_q - 1'b1;
    else             cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWR_ACT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // self-refresh exit bypasses the clock
  assign state_o = (state_q == PWR_SREF && cke_i) ? PWR_ACT : state_q;
endmodule

// File: rtl/ddr_ctl_tracker.sv
module ddr_ctl_tracker
  import ddr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int ACC_CYC   = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cke_i,
  input  logic                        cs_ni,
  input  logic                        ras_ni,
  input  logic                        cas_ni,
  input  logic                        we_ni,
  input  logic [BANK_W-1:0]           ba_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic [2:0]                  cmd_o,
  output logic [NUM_BANKS-1:0]        bank_open_o,
  output logic [NUM_BANKS*ADDR_W-1:0] bank_row_o,
  output logic [ADDR_W-1:0]           mode_reg_o,
  output logic [ADDR_W-1:0]           ext_mode_reg_o,
  output logic [1:0]                  pwr_state_o,
  output logic                        err_o
);
  cmd_e  cmd;
  pwr_e  pwr_state;
  logic  exec, sref_entry, cke_err;
  logic  sel_open, is_rdwr, act_ok, rdwr_ok, seq_err, pre_en;
  logic  [NUM_BANKS-1:0] open_vec;
  cmd_e  cmd_q;
  logic  err_q;
  logic  [ADDR_W-1:0] mr_q, emr_q;

  ddr_cmd_decode #(.BANK_W(BANK_W)) u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .ba_i   (ba_i),
    .cmd_o  (cmd)
  );

  assign sel_open = open_vec[ba_i];
  assign is_rdwr  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign act_ok   = exec && (cmd == CMD_ACT) && !sel_open;
  assign rdwr_ok  = exec && is_rdwr && sel_open;
  assign pre_en   = exec && (cmd == CMD_PRE);
  assign seq_err  = exec && (((cmd == CMD_ACT) && sel_open) || (is_rdwr && !sel_open));

  ddr_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ADDR_W)) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act_ok),
    .pre_i     (pre_en),
    .pre_all_i (addr_i[AP_BIT]),
    .bank_i    (ba_i),
    .row_i     (addr_i),
    .open_o    (open_vec),
    .row_o     (bank_row_o)
  );

  ddr_pwr_fsm #(.ACC_CYC(ACC_CYC)) u_pwr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cke_i        (cke_i),
    .ref_i        (cmd == CMD_REF),
    .rdwr_i       (is_rdwr),
    .start_acc_i  (rdwr_ok),
    .any_open_i   (|open_vec),
    .state_o      (pwr_state),
    .exec_o       (exec),
    .sref_entry_o (sref_entry),
    .cke_err_o    (cke_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_NOP;
      err_q <= 1'b0;
      mr_q  <= '0;
      emr_q <= '0;
    end else begin
      cmd_q <= exec ? cmd : (sref_entry ? CMD_REF : CMD_NOP);
      err_q <= seq_err || cke_err;
      if (exec && cmd == CMD_MRS)  mr_q  <= addr_i;
      if (exec && cmd == CMD_EMRS) emr_q <= addr_i;
    end
  end

  assign cmd_o          = cmd_q;
  assign err_o          = err_q;
  assign mode_reg_o     = mr_q;
  assign ext_mode_reg_o = emr_q;
  assign bank_open_o    = open_vec;
  assign pwr_state_o    = pwr_state;
endmodule

// File: rtl/ddr_ctl_tracker_chk.sv
module ddr_ctl_tracker_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_ni,
  input logic [2:0]           cmd_o,
  input logic                 err_o,
  input logic [1:0]           pwr_state_o,
  input logic [NUM_BANKS-1:0] bank_open_o
);
  // R2
  cs_high_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o == 3'd0));

  // R6
  err_keeps_table_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (bank_open_o == $past(bank_open_o)));

  // R7
  ppd_all_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd1) |-> (bank_open_o == '0));

  // R8
  apd_row_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd2) |-> (bank_open_o != '0));

  // R9
  pd_no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwr_state_o == 2'd1) || (pwr_state_o == 2'd2)) |-> (cmd_o == 3'd0));
endmodule

bind ddr_ctl_tracker ddr_ctl_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .cmd_o       (cmd_o),
  .err_o       (err_o),
  .pwr_state_o (pwr_state_o),
  .bank_open_o (bank_open_o)
);

// File: tb/ddr_ctl_tracker_tb.sv
module ddr_ctl_tracker_tb;
  localparam int NB = 4;
  localparam int AW = 12;
  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010,
                         REF = 3'b001, MRS = 3'b000, NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [AW-1:0] addr = '0;
  logic [2:0] cmd;
  logic [NB-1:0] bopen;
  logic [NB*AW-1:0] brow;
  logic [AW-1:0] mr, emr;
  logic [1:0] pwr;
  logic err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ddr_ctl_tracker #(.NUM_BANKS(NB), .ADDR_W(AW), .AP_BIT(10), .ACC_CYC(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .cmd_o(cmd),
    .bank_open_o(bopen), .bank_row_o(brow), .mode_reg_o(mr),
    .ext_mode_reg_o(emr), .pwr_state_o(pwr), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] rcw, input logic cs, input logic [1:0] b,
                      input logic [AW-1:0] a, input logic ck);
    {ras_n, cas_n, we_n} = rcw;
    cs_n = cs; ba = b; addr = a; cke = ck;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] row_of(input int b);
    return brow[b*AW +: AW];
  endfunction

  task automatic t_reset();
    chk("R12 cmd", cmd, 0);
    chk("R12 open", bopen, 0);
    chk("R12 rows", brow, 0);
    chk("R12 mr", {mr, emr}, 0);
    chk("R12 pwr", pwr, 0);
    chk("R12 err", err, 0);
  endtask

  task automatic t_activate();
    step(ACT, 0, 1, 12'h123, 1);
    chk("R1 act code", cmd, 1);
    chk("R3 open", bopen, 4'b0010);
    chk("R3 row", row_of(1), 12'h123);
    step(RD, 0, 1, 12'h004, 1);
    chk("R1 rd code", cmd, 2);
    chk("R1 rd err", err, 0);
    step(WR, 0, 1, 12'h008, 1);
    chk("R1 wr code", cmd, 3);
    step(3'b110, 0, 1, 12'h0, 1);
    chk("R1 110 nop", cmd, 0);
    step(NOP, 0, 0, 12'h0, 1);
  endtask

  task automatic t_seq_err();
    step(ACT, 0, 1, 12'h456, 1);
    chk("R6 act open err", err, 1);
    chk("R6 row kept", row_of(1), 12'h123);
    step(RD, 0, 2, 12'h0, 1);
    chk("R6 rd closed err", err, 1);
    chk("R6 bank2 closed", bopen, 4'b0010);
    step(NOP, 0, 0, 12'h0, 1);
    chk("R6 err clears", err, 0);
  endtask

  task automatic t_cs_high();
    step(ACT, 1, 2, 12'h0aa, 1);
    chk("R2 cmd nop", cmd, 0);
    chk("R2 table", bopen, 4'b0010);
  endtask

  task automatic t_precharge();
    step(ACT, 0, 0, 12'h011, 1);
    step(ACT, 0, 3, 12'h033, 1);
    chk("R3 three open", bopen, 4'b1011);
    step(PRE, 0, 1, 12'h000, 1);
    chk("R4 single", bopen, 4'b1001);
    chk("R1 pre code", cmd, 4);
    step(PRE, 0, 0, 12'h400, 1);
    chk("R4 all", bopen, 4'b0000);
  endtask

  task automatic t_mode();
    step(MRS, 0, 0, 12'h032, 1);
    chk("R5 mrs code", cmd, 6);
    chk("R5 mr", mr, 12'h032);
    step(MRS, 0, 1, 12'h001, 1);
    chk("R5 emrs code", cmd, 7);
    chk("R5 emr", emr, 12'h001);
    chk("R5 mr kept", mr, 12'h032);
    step(REF, 0, 0, 12'h0, 1);
    chk("R1 ref code", cmd, 5);
  endtask

  task automatic t_ppd();
    step(NOP, 0, 0, 12'h0, 0);
    chk("R7 ppd", pwr, 1);
    step(ACT, 0, 2, 12'h0, 0);
    chk("R9 ppd ignore cmd", cmd, 0);
    chk("R9 ppd ignore bank", bopen, 0);
    step(ACT, 0, 2, 12'h0, 1);
    chk("R9 ppd exit", pwr, 0);
    chk("R9 exit edge ignored", bopen, 0);
  endtask

  task automatic t_apd();
    step(ACT, 0, 0, 12'h077, 1);
    step(NOP, 0, 0, 12'h0, 0);
    chk("R8 apd", pwr, 2);
    step(PRE, 0, 0, 12'h400, 0);
    chk("R9 apd ignore", bopen, 4'b0001);
    step(NOP, 0, 0, 12'h0, 1);
    chk("R9 apd exit", pwr, 0);
  endtask

  task automatic t_sref();
    step(PRE, 0, 0, 12'h400, 1);
    step(REF, 0, 0, 12'h0, 0);
    chk("R7 sref", pwr, 3);
    chk("R7 sref cmd", cmd, 5);
    step(ACT, 0, 1, 12'h0, 0);
    chk("R9 sref ignore", bopen, 0);
    chk("R9 sref stay", pwr, 3);
    {ras_n, cas_n, we_n} = NOP;
    cke = 1'b1;
    #1;
    chk("R10 async exit", pwr, 0);
    @(posedge clk); #1;
    chk("R10 stays active", pwr, 0);
  endtask

  task automatic t_access();
    step(ACT, 0, 0, 12'h055, 1);
    step(RD, 0, 0, 12'h0, 1);
    chk("R11 rd ok", err, 0);
    step(NOP, 0, 0, 12'h0, 1);
    step(NOP, 0, 0, 12'h0, 0);
    chk("R11 last edge err", err, 1);
    chk("R11 stays active", pwr, 0);
    step(NOP, 0, 0, 12'h0, 0);
    chk("R11 window over", err, 0);
    chk("R8 apd after window", pwr, 2);
    step(NOP, 0, 0, 12'h0, 1);
    step(WR, 0, 0, 12'h0, 0);
    chk("R11 same-edge err", err, 1);
    chk("R11 same-edge active", pwr, 0);
    step(NOP, 0, 0, 12'h0, 1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_activate();
    t_seq_err();
    t_cs_high();
    t_precharge();
    t_mode();
    t_ppd();
    t_apd();
    t_sref();
    t_access();
    done = 1;
    finish_run();
  end
endmodule